// File: doc/BRIEF.md
# UART data buffer front end

This block is the register-side buffer stage of a UART. It sits between a CPU register bus and the serial shift engines. A single data address serves both directions: a bus write places a character in a one-entry transmit holding buffer, and a bus read returns the oldest character of a two-entry receive FIFO. A separate status byte reports receive-complete, transmit-complete, holding-buffer-empty and the per-character receive error flags.

Toward the transmit shifter the block offers a load strobe with the character. The strobe is raised while the transmitter is enabled, the shifter reports idle and the holding buffer is full. Toward the receiver it takes a push port carrying a character with its framing and parity error bits. The character size, from 5 to 8 bits, the two enables and the receive interrupt enable are plain inputs. Serialization, baud timing, parity generation and multiprocessor addressing belong to other blocks.

Top module: `uart_dbuf_front`

## Requirements
- R1: A pulse on `bus_wr` with `bus_wdata` stores the character in the transmit holding buffer, which is presented on `tx_data`. `bus_rdata` shows the character at the head of the receive FIFO.
- R2: A write made while the buffer-empty flag (status bit 5) is 0 is dropped, and `tx_data` keeps the held character.
- R3: `tx_load` is high exactly while `tx_en` is 1, `tx_busy` is 0 and the holding buffer is full. While it is high, `tx_data` carries the character being handed over.
- R4: The buffer-empty flag (status bit 5) reads 0 from the cycle after an accepted write, and reads 1 again from the cycle after `tx_load` was high.
- R5: `char_size` encodes 0=5, 1=6, 2=7 and 3=8 data bits. On transmit, the bits of a written character above that size are stored as zero.
- R6: On receive, the bits of a pushed character above the character size read back as zero.
- R7: The receive FIFO holds two characters in arrival order. Each `bus_rd` while it holds data removes the head entry.
- R8: Receive-complete (status bit 7) is 1 while the FIFO holds at least one character and 0 when it is empty.
- R9: While `rx_en` is 0 the FIFO is emptied on every cycle and `rx_push` is ignored, so receive-complete reads 0 from the cycle after `rx_en` falls.
- R10: The status byte is, from bit 7 down: receive-complete, transmit-complete, buffer-empty, frame error, overrun, parity error, double-speed, multiprocessor. It resets to 0x20. A `stat_wr` writes bits 1 and 0 directly, and a 1 in bit 6 clears transmit-complete. Transmit-complete is set by a `tx_done` pulse while the holding buffer is empty.
- R11: The frame error (bit 4) and parity error (bit 2) are stored with each character and show the head entry. The three error bits read 0 when the FIFO is empty.
- R12: A push while the FIFO holds two characters and no read happens in the same cycle discards the new character and sets the overrun bit (bit 3) of the head entry.
- R13: A read while the FIFO is empty returns 0 on `bus_rdata` and leaves the FIFO unchanged.
- R14: `irq` is high exactly when receive-complete and `rxc_ie` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the data address |
| bus_rd | input | 1 | Read strobe for the data address |
| bus_wdata | input | 8 | Write data for the data address |
| bus_rdata | output | 8 | Receive FIFO head, zero when empty |
| stat_wr | input | 1 | Write strobe for the status byte |
| stat_wdata | input | 8 | Write data for the status byte |
| stat_rdata | output | 8 | Status byte |
| char_size | input | 2 | Character size code (0..3 = 5..8 bits) |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable, low flushes the FIFO |
| rxc_ie | input | 1 | Receive interrupt enable |
| irq | output | 1 | Receive interrupt request |
| tx_busy | input | 1 | Transmit shifter is occupied |
| tx_done | input | 1 | Transmit shifter finished a character |
| tx_load | output | 1 | Handoff strobe toward the shifter |
| tx_data | output | 8 | Character held for the shifter |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_fe | input | 1 | Frame error of the received character |
| rx_pe | input | 1 | Parity error of the received character |

## Verification
The assertions check on every cycle the relations among the ports: a handoff only happens under its three conditions, the buffer-empty flag rises after a handoff and falls after an accepted write, a blocked write does not change the held character, disabling the receiver empties the FIFO, and an empty FIFO reads as zero with clean error bits and no interrupt. Only the bench scenarios can show what depends on data history: FIFO order across two pushes, discard of a third character with the overrun mark on the head, error bits moving with their entry, masking for each character size, and the transmit-complete and writable status bits.

// File: rtl/udb_pkg.sv
`timescale 1ns/1ps
package udb_pkg;
    localparam int DW = 8;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          fe;
        logic          pe;
        logic          dor;
    } rx_ent_t;

    // code 0..3 selects 5..8 significant bits
    function automatic logic [DW-1:0] size_mask(input logic [1:0] code);
        return {DW{1'b1}} >> (2'd3 - code);
    endfunction
endpackage

// File: rtl/udb_tx_hold.sv
`timescale 1ns/1ps
module udb_tx_hold
    import udb_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    char_size,
    input  logic          tx_en,
    input  logic          tx_busy,
    input  logic          tx_done,
    input  logic          txc_clr,
    output logic          tx_load,
    output logic [DW-1:0] tx_data,
    output logic          empty,
    output logic          txc
);
    typedef struct packed {
        logic          full;
        logic          txc;
        logic [DW-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d  = hold_q;
        tx_load = tx_en && !tx_busy && hold_q.full;
        if (tx_load) begin
            hold_d.full = 1'b0;
        end else if (wr && !hold_q.full) begin
            hold_d.full = 1'b1;
            hold_d.data = wdata & size_mask(char_size);
        end
        if (tx_done && !hold_q.full) begin
            hold_d.txc = 1'b1;
        end else if (txc_clr) begin
            hold_d.txc = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign tx_data = hold_q.data;
    assign empty   = !hold_q.full;
    assign txc     = hold_q.txc;
endmodule

// File: rtl/udb_rx_fifo.sv
`timescale 1ns/1ps
module udb_rx_fifo
    import udb_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_char,
    input  logic          push_fe,
    input  logic          push_pe,
    input  logic [1:0]    char_size,
    input  logic          pop,
    output rx_ent_t       head,
    output logic          nonempty
);
    localparam int PW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        rx_ent_t [DEPTH-1:0] mem;
        logic [PW-1:0]       rd;
        logic [PW-1:0]       wr;
        logic [CW-1:0]       cnt;
    } fifo_t;

    fifo_t fifo_d, fifo_q;
    logic  pop_ok;
    logic  is_full;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        fifo_d  = fifo_q;
        is_full = (fifo_q.cnt == FULL);
        pop_ok  = pop && (fifo_q.cnt != '0);
        if (flush) begin
            fifo_d.rd  = '0;
            fifo_d.wr  = '0;
            fifo_d.cnt = '0;
        end else begin
            if (pop_ok) begin
                fifo_d.rd  = step(fifo_q.rd);
                fifo_d.cnt = fifo_d.cnt - 1'b1;
            end
            if (push) begin
                if (!is_full || pop_ok) begin
                    fifo_d.mem[fifo_q.wr].data = push_char & size_mask(char_size);
                    fifo_d.mem[fifo_q.wr].fe   = push_fe;
                    fifo_d.mem[fifo_q.wr].pe   = push_pe;
                    fifo_d.mem[fifo_q.wr].dor  = 1'b0;
                    fifo_d.wr  = step(fifo_q.wr);
                    fifo_d.cnt = fifo_d.cnt + 1'b1;
                end else begin
                    fifo_d.mem[fifo_q.rd].dor = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_q <= '0;
        end else begin
            fifo_q <= fifo_d;
        end
    end

    assign nonempty = (fifo_q.cnt != '0);
    assign head     = nonempty ? fifo_q.mem[fifo_q.rd] : '0;
endmodule

// File: rtl/udb_status.sv
`timescale 1ns/1ps
module udb_status
    import udb_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    stat_wr,
    input  logic [7:0] stat_wdata,
    input  logic    rxc,
    input  logic    txc,
    input  logic    udre,
    input  rx_ent_t head,
    output logic    txc_clr,
    output logic [7:0] stat_rdata
);
    typedef struct packed {
        logic dbl;
        logic mpm;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (stat_wr) begin
            ctl_d.dbl = stat_wdata[1];
            ctl_d.mpm = stat_wdata[0];
        end
        txc_clr = stat_wr && stat_wdata[6];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // bit order is decoded by software: keep it fixed
    assign stat_rdata = {rxc, txc, udre, head.fe, head.dor, head.pe, ctl_q.dbl, ctl_q.mpm};
endmodule

// File: rtl/uart_dbuf_front.sv
`timescale 1ns/1ps
module uart_dbuf_front
    import udb_pkg::*;
#(
    parameter int RX_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       stat_wr,
    input  logic [7:0] stat_wdata,
    output logic [7:0] stat_rdata,
    input  logic [1:0] char_size,
    input  logic       tx_en,
    input  logic       rx_en,
    input  logic       rxc_ie,
    output logic       irq,
    input  logic       tx_busy,
    input  logic       tx_done,
    output logic       tx_load,
    output logic [7:0] tx_data,
    input  logic       rx_push,
    input  logic [7:0] rx_char,
    input  logic       rx_fe,
    input  logic       rx_pe
);
    rx_ent_t head;
    logic    rxc;
    logic    udre;
    logic    txc;
    logic    txc_clr;

    udb_tx_hold i_tx_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .char_size (char_size),
        .tx_en     (tx_en),
        .tx_busy   (tx_busy),
        .tx_done   (tx_done),
        .txc_clr   (txc_clr),
        .tx_load   (tx_load),
        .tx_data   (tx_data),
        .empty     (udre),
        .txc       (txc)
    );

    udb_rx_fifo #(.DEPTH(RX_DEPTH)) i_rx_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (!rx_en),
        .push      (rx_push && rx_en),
        .push_char (rx_char),
        .push_fe   (rx_fe),
        .push_pe   (rx_pe),
        .char_size (char_size),
        .pop       (bus_rd),
        .head      (head),
        .nonempty  (rxc)
    );

    udb_status i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_wr    (stat_wr),
        .stat_wdata (stat_wdata),
        .rxc        (rxc),
        .txc        (txc),
        .udre       (udre),
        .head       (head),
        .txc_clr    (txc_clr),
        .stat_rdata (stat_rdata)
    );

    assign bus_rdata = head.data;
    assign irq       = rxc && rxc_ie;
endmodule

// File: rtl/udb_checker.sv
`timescale 1ns/1ps
module udb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       st_rxc,
    input logic       st_udre,
    input logic [2:0] st_err,
    input logic       tx_en,
    input logic       tx_busy,
    input logic       tx_load,
    input logic [7:0] tx_data,
    input logic       rx_en,
    input logic       rxc_ie,
    input logic       irq
);
    p_load_cond_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |-> (tx_en && !tx_busy && !st_udre));

    p_udre_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_load |=> st_udre);

    p_udre_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && st_udre) |=> !st_udre);

    p_hold_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_udre && !tx_load) |=> $stable(tx_data));

    p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> !st_rxc);

    p_empty_read_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rxc |-> (bus_rdata == 8'h00));

    p_empty_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !st_rxc |-> (st_err == 3'b000));

    p_irq_r14: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (st_rxc && rxc_ie));
endmodule

bind uart_dbuf_front udb_checker i_udb_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .st_rxc    (stat_rdata[7]),
    .st_udre   (stat_rdata[5]),
    .st_err    (stat_rdata[4:2]),
    .tx_en     (tx_en),
    .tx_busy   (tx_busy),
    .tx_load   (tx_load),
    .tx_data   (tx_data),
    .rx_en     (rx_en),
    .rxc_ie    (rxc_ie),
    .irq       (irq)
);

// File: tb/test_uart_dbuf_front.sv
`timescale 1ns/1ps
module test_uart_dbuf_front;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic       stat_wr = 1'b0;
    logic [7:0] stat_wdata = '0, stat_rdata;
    logic [1:0] char_size = 2'd3;
    logic       tx_en = 1'b0, rx_en = 1'b0, rxc_ie = 1'b0, irq;
    logic       tx_busy = 1'b0, tx_done = 1'b0, tx_load;
    logic [7:0] tx_data;
    logic       rx_push = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_fe = 1'b0, rx_pe = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    uart_dbuf_front i_uart_dbuf_front (.*);

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_data(input logic [7:0] v);
        @(negedge clk); bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk); bus_wr = 1'b0; #1;
    endtask

    task automatic wr_stat(input logic [7:0] v);
        @(negedge clk); stat_wr = 1'b1; stat_wdata = v;
        @(negedge clk); stat_wr = 1'b0; #1;
    endtask

    task automatic push(input logic [7:0] c, input logic fe, input logic pe);
        @(negedge clk); rx_push = 1'b1; rx_char = c; rx_fe = fe; rx_pe = pe;
        @(negedge clk); rx_push = 1'b0; rx_fe = 1'b0; rx_pe = 1'b0; #1;
    endtask

    task automatic rd_expect(input string req, input logic [7:0] exp);
        @(negedge clk); bus_rd = 1'b1; #1;
        chk(req, bus_rdata, exp);
        @(negedge clk); bus_rd = 1'b0; #1;
    endtask

    task automatic t_reset();
        chk("R10 reset status", stat_rdata, 8'h20);
        chk("R13 reset rdata", bus_rdata, 8'h00);
        chk("R14 reset irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_tx_basic();
        char_size = 2'd3; tx_en = 1'b0; tx_busy = 1'b0;
        wr_data(8'hA5);
        chk("R1 tx_data after write", tx_data, 8'hA5);
        chk("R4 udre cleared", {7'd0, stat_rdata[5]}, 8'h00);
        wr_data(8'h3C);
        chk("R2 blocked write", tx_data, 8'hA5);
        chk("R3 no load while disabled", {7'd0, tx_load}, 8'h00);
        @(negedge clk); tx_en = 1'b1; #1;
        chk("R3 load strobe", {7'd0, tx_load}, 8'h01);
        step();
        chk("R4 udre set after load", {7'd0, stat_rdata[5]}, 8'h01);
        chk("R3 single load", {7'd0, tx_load}, 8'h00);
        tx_busy = 1'b1;
        wr_data(8'h5A);
        chk("R3 no load while busy", {7'd0, tx_load}, 8'h00);
        @(negedge clk); tx_busy = 1'b0; #1;
        chk("R3 load after idle", {7'd0, tx_load}, 8'h01);
        chk("R3 handed data", tx_data, 8'h5A);
        step();
        tx_en = 1'b0;
    endtask

    task automatic t_tx_mask();
        char_size = 2'd0;
        wr_data(8'hFF);
        chk("R5 five bit mask", tx_data, 8'h1F);
        @(negedge clk); tx_en = 1'b1; @(negedge clk); tx_en = 1'b0;
        char_size = 2'd2;
        wr_data(8'hFF);
        chk("R5 seven bit mask", tx_data, 8'h7F);
        @(negedge clk); tx_en = 1'b1; @(negedge clk); tx_en = 1'b0; #1;
        chk("R4 drained", {7'd0, stat_rdata[5]}, 8'h01);
        char_size = 2'd3;
    endtask

    task automatic t_status();
        @(negedge clk); tx_done = 1'b1; @(negedge clk); tx_done = 1'b0; #1;
        chk("R10 txc set", stat_rdata, 8'h60);
        wr_stat(8'h43);
        chk("R10 txc clear and low bits", stat_rdata, 8'h23);
        wr_stat(8'h00);
        chk("R10 low bits cleared", stat_rdata, 8'h20);
    endtask

    task automatic t_rx_order();
        rx_en = 1'b1; rxc_ie = 1'b0;
        push(8'h11, 1'b0, 1'b0);
        chk("R8 rxc set", {7'd0, stat_rdata[7]}, 8'h01);
        chk("R14 irq masked", {7'd0, irq}, 8'h00);
        rxc_ie = 1'b1; #1;
        chk("R14 irq raised", {7'd0, irq}, 8'h01);
        push(8'h22, 1'b0, 1'b0);
        rd_expect("R7 first out", 8'h11);
        rd_expect("R1 R7 second out", 8'h22);
        chk("R8 rxc cleared", {7'd0, stat_rdata[7]}, 8'h00);
        chk("R14 irq dropped", {7'd0, irq}, 8'h00);
        rxc_ie = 1'b0;
    endtask

    task automatic t_rx_mask();
        char_size = 2'd1;
        push(8'hFF, 1'b0, 1'b0);
        rd_expect("R6 six bit mask", 8'h3F);
        char_size = 2'd0;
        push(8'hE7, 1'b0, 1'b0);
        rd_expect("R6 five bit mask", 8'h07);
        char_size = 2'd3;
    endtask

    task automatic t_rx_err();
        push(8'h41, 1'b1, 1'b0);
        push(8'h42, 1'b0, 1'b1);
        chk("R11 head frame error", {5'd0, stat_rdata[4:2]}, 8'h04);
        rd_expect("R11 first char", 8'h41);
        chk("R11 next parity error", {5'd0, stat_rdata[4:2]}, 8'h01);
        rd_expect("R11 second char", 8'h42);
        chk("R11 empty clean", {5'd0, stat_rdata[4:2]}, 8'h00);
    endtask

    task automatic t_overrun();
        push(8'hA1, 1'b0, 1'b0);
        push(8'hA2, 1'b0, 1'b0);
        chk("R12 no overrun yet", {7'd0, stat_rdata[3]}, 8'h00);
        push(8'hA3, 1'b0, 1'b0);
        chk("R12 overrun on head", {7'd0, stat_rdata[3]}, 8'h01);
        rd_expect("R12 head kept", 8'hA1);
        chk("R12 next no overrun", {7'd0, stat_rdata[3]}, 8'h00);
        rd_expect("R12 second kept", 8'hA2);
        chk("R12 third discarded", {7'd0, stat_rdata[7]}, 8'h00);
    endtask

    task automatic t_flush();
        push(8'h55, 1'b0, 1'b0);
        push(8'h66, 1'b0, 1'b0);
        @(negedge clk); rx_en = 1'b0;
        step();
        chk("R9 flushed rxc", {7'd0, stat_rdata[7]}, 8'h00);
        chk("R9 flushed rdata", bus_rdata, 8'h00);
        push(8'h77, 1'b0, 1'b0);
        @(negedge clk); rx_en = 1'b1; #1;
        chk("R9 push ignored while off", {7'd0, stat_rdata[7]}, 8'h00);
    endtask

    task automatic t_empty_read();
        rd_expect("R13 empty read", 8'h00);
        chk("R13 still empty", {7'd0, stat_rdata[7]}, 8'h00);
        push(8'h99, 1'b0, 1'b0);
        rd_expect("R13 fifo intact", 8'h99);
        chk("R13 empty after", {7'd0, stat_rdata[7]}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_tx_basic();
        t_tx_mask();
        t_status();
        t_rx_order();
        t_rx_mask();
        t_rx_err();
        t_overrun();
        t_flush();
        t_empty_read();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule